// File: doc/BRIEF.md
# Link Authentication Step Pacer

This block paces the transmitter side of a link-authentication handshake. Once its enable is raised it walks through four handshake steps in a fixed order: read the receiver key, read the receiver capabilities, write the session nonce, and write the transmitter key. Each step is preceded by its own programmable wait. For each step the block raises a one-cycle request and then holds until an external agent, which performs the actual bus transaction, returns a done acknowledge. The bus transfers and the cipher are handled elsewhere.

After the transmitter-key write has been acknowledged, the block schedules periodic link-integrity checks. It counts frame strobes. On every period boundary it waits a programmable number of line-sync strobes before raising a one-cycle check request. All timing comes from three strobes supplied by the system: a millisecond tick, a frame strobe and a line-sync strobe. Dropping the enable abandons the handshake at any point.

All codes at zero give the fastest behaviour: every step is issued without a wait, checks come every 128 frames, and the check is raised right at the frame boundary.

Top module: `auth_pacer`

## Requirements
- R1: While reset is high, and while `en` is low, `step_req` is 0 and `chk_req` is 0 whatever the strobes and codes do.
- R2: Step requests come one at a time as single-cycle pulses on `step_req`. Bit 0 is the receiver-key read, bit 1 the capability read, bit 2 the nonce write and bit 3 the transmitter-key write, always in that order. The next step's wait starts only once `step_done` is sampled high after the current request.
- R3: The wait before step k is selected by `dly_codes[3k+2:3k]`. Codes 0 to 7 mean 0, 1, 2, 5, 10, 25, 50 and 100 millisecond ticks. The wait is loaded at the edge that starts it, and a tick sampled at that edge does not count. The request is set at the edge after the edge that samples the last required tick.
- R4: With a wait code of 0, the request is set at the second rising edge after the enable is first sampled high, or after `step_done` is sampled.
- R5: `chk_period_code` values 0, 1, 2 and 3 give a check period of 128, 64, 32 and 16 frame strobes. Counting starts only after the transmitter-key acknowledge; a frame strobe sampled in the acknowledge cycle is not counted. Every period-th counted frame strobe arms a check.
- R6: `chk_offs_code` values 0 to 7 delay an armed check by 0, 8, 16, 32, 64, 128, 256 or 512 line strobes. A line strobe sampled together with the arming frame strobe is not counted. `chk_req` is set at the edge after the edge that samples the last required line strobe, or one edge after arming when the offset is 0. A new boundary that arrives while a check is still pending restarts the offset.
- R7: At the first rising edge that samples `en` low, both request outputs clear and any pending step or check is dropped. The next enable restarts from the first wait.
- R8: Checks repeat every period for as long as `en` stays high, and each `chk_req` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Start and hold the handshake; low returns to idle |
| ms_tick | input | 1 | One-cycle millisecond tick |
| frame_stb | input | 1 | One-cycle frame strobe |
| line_stb | input | 1 | One-cycle line-sync strobe |
| dly_codes | input | 12 | Four 3-bit wait codes, step k at bits [3k+2:3k] |
| chk_period_code | input | 2 | Check period select |
| chk_offs_code | input | 3 | Check line offset select |
| step_done | input | 1 | Acknowledge of the outstanding step |
| step_req | output | 4 | One-hot single-cycle step request |
| chk_req | output | 1 | Single-cycle link-integrity check request |

## Verification
A period boundary and a line strobe can occur in the same cycle. So can a pending offset reaching zero and the next boundary re-arming the count. A frame strobe can also arrive in the very cycle that acknowledges the transmitter-key write. To provoke these, the bench uses strobe periods that divide one another, including a line strobe on every cycle, and an acknowledge latency of zero. A behavioural model is updated at each edge and compared with both outputs at every cycle. In these coincident cycles, an off-by-one count or a wrong priority shows up as a request that comes one cycle early or late.

// File: rtl/auth_pacer_pkg.sv
package auth_pacer_pkg;
  localparam int N_STEPS = 4;
  localparam int STEP_W  = $clog2(N_STEPS);
  localparam int CODE_W  = 3;
  localparam int MS_W    = 7;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_ACK, PH_RUN} phase_t;

  // nonlinear wait scale in millisecond ticks
  function automatic logic [MS_W-1:0] code_to_ms(input logic [CODE_W-1:0] c);
    case (c)
      3'd0: code_to_ms = 7'd0;
      3'd1: code_to_ms = 7'd1;
      3'd2: code_to_ms = 7'd2;
      3'd3: code_to_ms = 7'd5;
      3'd4: code_to_ms = 7'd10;
      3'd5: code_to_ms = 7'd25;
      3'd6: code_to_ms = 7'd50;
      default: code_to_ms = 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/auth_pacer_wait.sv
module auth_pacer_wait
  import auth_pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              ms_tick,
  output logic              expired
);
  logic [MS_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)
      remain_q <= '0;
    else if (load)
      remain_q <= code_to_ms(code);
    else if (ms_tick && remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);
endmodule

// File: rtl/auth_pacer_sched.sv
module auth_pacer_sched #(
  parameter int BASE_FRAMES = 128,
  parameter int LINE_UNIT   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       frame_stb,
  input  logic       line_stb,
  input  logic [1:0] period_code,
  input  logic [2:0] offs_code,
  output logic       chk_pulse
);
  localparam int FR_W = $clog2(BASE_FRAMES);
  localparam int LN_W = $clog2(LINE_UNIT * 64) + 1;
  localparam logic [FR_W:0]   BASE_V = BASE_FRAMES[FR_W:0];
  localparam logic [LN_W-1:0] UNIT_V = LINE_UNIT[LN_W-1:0];

  logic [FR_W-1:0] fcnt_q;
  logic [LN_W-1:0] lcnt_q;
  logic            pend_q;
  logic [FR_W:0]   period;
  logic [LN_W-1:0] offs;
  logic            boundary;

  assign period   = BASE_V >> period_code;
  assign offs     = (offs_code == 3'd0) ? '0 : (UNIT_V << (offs_code - 3'd1));
  assign boundary = frame_stb && ({1'b0, fcnt_q} == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      fcnt_q    <= '0;
      lcnt_q    <= '0;
      pend_q    <= 1'b0;
      chk_pulse <= 1'b0;
    end else begin
      chk_pulse <= pend_q && (lcnt_q == '0);
      if (boundary) begin
        fcnt_q <= '0;
        pend_q <= 1'b1;
        lcnt_q <= offs;
      end else begin
        if (frame_stb) fcnt_q <= fcnt_q + 1'b1;
        if (pend_q) begin
          if (lcnt_q == '0)  pend_q <= 1'b0;
          else if (line_stb) lcnt_q <= lcnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/auth_pacer.sv
module auth_pacer
  import auth_pacer_pkg::*;
#(
  parameter int BASE_FRAMES = 128,
  parameter int LINE_UNIT   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      ms_tick,
  input  logic                      frame_stb,
  input  logic                      line_stb,
  input  logic [N_STEPS*CODE_W-1:0] dly_codes,
  input  logic [1:0]                chk_period_code,
  input  logic [2:0]                chk_offs_code,
  input  logic                      step_done,
  output logic [N_STEPS-1:0]        step_req,
  output logic                      chk_req
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  phase_t             ph_q;
  logic [STEP_W-1:0]  step_q;
  logic [CODE_W-1:0]  code_arr [N_STEPS];
  logic               wait_load;
  logic [CODE_W-1:0]  wait_code;
  logic               wait_expired;
  logic               sched_run;

  for (genvar g = 0; g < N_STEPS; g++) begin : g_code
    assign code_arr[g] = dly_codes[g*CODE_W +: CODE_W];
  end

  always_comb begin
    wait_load = 1'b0;
    wait_code = code_arr[0];
    if (en) begin
      if (ph_q == PH_IDLE) begin
        wait_load = 1'b1;
      end else if (ph_q == PH_ACK && step_done && step_q != LAST_STEP) begin
        wait_load = 1'b1;
        wait_code = code_arr[step_q + 1'b1];
      end
    end
  end

  auth_pacer_wait u_wait (
    .clk     (clk),
    .rst     (rst),
    .load    (wait_load),
    .code    (wait_code),
    .ms_tick (ms_tick),
    .expired (wait_expired)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q     <= PH_IDLE;
      step_q   <= '0;
      step_req <= '0;
    end else begin
      step_req <= '0;
      case (ph_q)
        PH_IDLE: begin
          ph_q   <= PH_WAIT;
          step_q <= '0;
        end
        PH_WAIT: if (wait_expired) begin
          step_req[step_q] <= 1'b1;
          ph_q             <= PH_ACK;
        end
        PH_ACK: if (step_done) begin
          if (step_q == LAST_STEP) begin
            ph_q <= PH_RUN;
          end else begin
            step_q <= step_q + 1'b1;
            ph_q   <= PH_WAIT;
          end
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  assign sched_run = en && (ph_q == PH_RUN);

  auth_pacer_sched #(
    .BASE_FRAMES (BASE_FRAMES),
    .LINE_UNIT   (LINE_UNIT)
  ) u_sched (
    .clk         (clk),
    .rst         (rst),
    .run         (sched_run),
    .frame_stb   (frame_stb),
    .line_stb    (line_stb),
    .period_code (chk_period_code),
    .offs_code   (chk_offs_code),
    .chk_pulse   (chk_req)
  );
endmodule

// File: rtl/auth_pacer_props.sv
module auth_pacer_props (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] step_req,
  input logic       chk_req
);
  logic [1:0] expect_idx_q;
  logic       key_sent_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      expect_idx_q <= '0;
      key_sent_q   <= 1'b0;
    end else if (|step_req) begin
      expect_idx_q <= expect_idx_q + 1'b1;
      if (step_req[3]) key_sent_q <= 1'b1;
    end
  end

  assert_onehot_req_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_req));

  assert_step_order_R2: assert property (@(posedge clk) disable iff (rst)
    (|step_req) |-> step_req[expect_idx_q]);

  assert_req_single_R2: assert property (@(posedge clk) disable iff (rst)
    (|step_req) |=> (step_req == 4'b0000));

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (step_req == 4'b0000 && !chk_req));

  assert_chk_after_keys_R5: assert property (@(posedge clk) disable iff (rst)
    chk_req |-> key_sent_q);

  assert_chk_single_R8: assert property (@(posedge clk) disable iff (rst)
    chk_req |=> !chk_req);
endmodule

bind auth_pacer auth_pacer_props u_props (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .step_req (step_req),
  .chk_req  (chk_req)
);

// File: tb/auth_pacer_bench.sv
`timescale 1ns/1ps
module auth_pacer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        ms_tick = 1'b0;
  logic        frame_stb = 1'b0;
  logic        line_stb = 1'b0;
  logic [11:0] dly_codes = '0;
  logic [1:0]  chk_period_code = '0;
  logic [2:0]  chk_offs_code = '0;
  logic        step_done = 1'b0;
  logic [3:0]  step_req;
  logic        chk_req;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit cmp_on = 0;

  always #4 clk = ~clk;  // 125 MHz

  auth_pacer u_auth_pacer (
    .clk(clk), .rst(rst), .en(en), .ms_tick(ms_tick), .frame_stb(frame_stb),
    .line_stb(line_stb), .dly_codes(dly_codes), .chk_period_code(chk_period_code),
    .chk_offs_code(chk_offs_code), .step_done(step_done), .step_req(step_req),
    .chk_req(chk_req)
  );

  // strobe generators
  int cyc = 0;
  int tick_p = 4, frame_p = 20, line_p = 3;
  always @(negedge clk) begin
    cyc++;
    ms_tick   = (cyc % tick_p == 0);
    frame_stb = (cyc % frame_p == 0);
    line_stb  = (cyc % line_p == 0);
  end

  // acknowledge agent
  int ack_lat = 0;
  int ack_wait = -1;
  always @(negedge clk) begin
    step_done = 1'b0;
    if (!en) ack_wait = -1;
    if (ack_wait > 0) begin
      ack_wait--;
      if (ack_wait == 0) begin step_done = 1'b1; ack_wait = -1; end
    end
    if (|step_req) begin
      if (ack_lat == 0) step_done = 1'b1;
      else ack_wait = ack_lat;
    end
  end

  function automatic int wait_ms(input int c);
    case (c)
      0: return 0;   1: return 1;   2: return 2;   3: return 5;
      4: return 10;  5: return 25;  6: return 50;  default: return 100;
    endcase
  endfunction

  function automatic int line_offs(input int c);
    int r = 0;
    if (c > 0) begin
      r = 8;
      for (int i = 1; i < c; i++) r = r * 2;
    end
    return r;
  endfunction

  // behavioural reference model, evaluated at each edge
  int m_phase = 0, m_step = 0, m_rem = 0, m_frames = 0, m_lines = 0;
  bit m_pend = 0;
  logic [3:0] m_req = '0;
  logic m_chk = 1'b0;
  int m_chk_count = 0;

  always @(posedge clk) begin
    m_req = '0;
    m_chk = 1'b0;
    if (rst || !en) begin
      m_phase = 0; m_pend = 0;
    end else begin
      case (m_phase)
        0: begin m_phase = 1; m_step = 0; m_rem = wait_ms(int'(dly_codes[2:0])); end
        1: if (m_rem == 0) begin m_req[m_step] = 1'b1; m_phase = 2; end
           else if (ms_tick) m_rem--;
        2: if (step_done) begin
             if (m_step == 3) begin m_phase = 3; m_frames = 0; m_pend = 0; end
             else begin
               m_step++;
               m_rem = wait_ms(int'(dly_codes[m_step*3 +: 3]));
               m_phase = 1;
             end
           end
        default: begin
          if (m_pend && m_lines == 0) begin m_chk = 1'b1; m_chk_count++; end
          if (frame_stb && m_frames == (128 >> chk_period_code) - 1) begin
            m_frames = 0; m_pend = 1; m_lines = line_offs(int'(chk_offs_code));
          end else begin
            if (frame_stb) m_frames++;
            if (m_pend) begin
              if (m_lines == 0) m_pend = 0;
              else if (line_stb) m_lines--;
            end
          end
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(step_req === m_req, tag, "step_req", int'(step_req), int'(m_req));
      check(chk_req === m_chk, tag, "chk_req", int'(chk_req), int'(m_chk));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    int c0;
    run(3);
    cmp_on = 1;
    tag = "R1";
    check(step_req == 4'b0 && chk_req == 1'b0, "R1", "reset outputs",
          int'({chk_req, step_req}), 0);
    rst = 1'b0;
    run(60);                                  // enable low, strobes running

    // zero waits, fast period, zero offset, immediate acknowledge
    tag = "R2 R4 R5";
    dly_codes = '0; chk_period_code = 2'd3; chk_offs_code = 3'd0;
    tick_p = 4; frame_p = 20; line_p = 3; ack_lat = 0;
    en = 1'b1;
    run(2);
    check(step_req == 4'b0001, "R4", "first request two edges after enable",
          int'(step_req), 1);
    run(1400);
    check(m_chk_count >= 3, "R8", "repeated checks in fast mode", m_chk_count, 3);

    tag = "R7";
    en = 1'b0;
    run(4);

    // nonlinear waits, longest period, offset 32 lines, coincident strobes
    tag = "R3 R6 R8";
    dly_codes = {3'd7, 3'd5, 3'd3, 3'd1};
    chk_period_code = 2'd0; chk_offs_code = 3'd3;
    tick_p = 4; frame_p = 10; line_p = 2; ack_lat = 5;
    c0 = m_chk_count;
    en = 1'b1;
    run(3400);
    check(m_chk_count - c0 >= 2, "R5", "128-frame period produced checks",
          m_chk_count - c0, 2);
    en = 1'b0;
    run(4);

    // 512-line offset with line strobe every cycle
    tag = "R5 R6 R8";
    dly_codes = {3'd0, 3'd6, 3'd4, 3'd2};
    chk_period_code = 2'd2; chk_offs_code = 3'd7;
    tick_p = 3; frame_p = 600; line_p = 1; ack_lat = 2;
    en = 1'b1;
    run(40000);
    en = 1'b0;
    run(4);

    // 64-frame period, 8-line offset
    tag = "R5 R6";
    dly_codes = {3'd2, 3'd0, 3'd1, 3'd0};
    chk_period_code = 2'd1; chk_offs_code = 3'd1;
    tick_p = 5; frame_p = 12; line_p = 4; ack_lat = 1;
    en = 1'b1;
    run(1800);
    en = 1'b0;
    run(3);

    // abort during a long wait, then during a pending acknowledge
    tag = "R7";
    dly_codes = {4{3'd7}}; tick_p = 2; ack_lat = 1;
    en = 1'b1;
    run(120);
    en = 1'b0;
    run(1);
    check(step_req == 4'b0 && chk_req == 1'b0, "R7", "outputs after abort",
          int'({chk_req, step_req}), 0);
    run(5);
    dly_codes = '0; ack_lat = 60;
    en = 1'b1;
    run(20);
    en = 1'b0;
    run(5);
    ack_lat = 0;
    en = 1'b1;
    run(2);
    check(step_req == 4'b0001, "R7", "restart from first step", int'(step_req), 1);
    run(200);
    en = 1'b0;
    run(10);
    finish_run();
  end
endmodule